// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called A and B. Each direction has its own capture register and capture clock. It also has its own output enable and its own source select. The select decides whether the opposite bus is driven with live data or with the value held in that direction's register. Each bus side appears as three separate signals: an input, an output and an output enable. The surrounding logic, or a bench, combines these into a resolved net.

A capture register loads on every rising edge of its clock, whatever the select and enable inputs are doing. The live path has no storage, so a change on one bus reaches the other bus with no clock edge. A build-time parameter makes both paths either true or inverting.

If both selects are set to live data and both directions are enabled, each bus drives the other. The pair of buses then keeps its last value once every outside driver lets go.

Top module: `regbus_xcvr`

## Requirements
- R1: On each rising edge of `ab_cap_clk`, the A-to-B register loads `a_in`. This happens for any setting of the selects and enables.
- R2: On each rising edge of `ba_cap_clk`, the B-to-A register loads `b_in`. This happens for any setting of the selects and enables.
- R3: `b_oe` follows `drive_b_en`, which is active high. `a_oe` is the inverse of `drive_a_en_n`, which is active low.
- R4: With `ab_use_stored` = 0, `b_out` equals `a_in` through the data path, with no clock edge between them. With `ab_use_stored` = 1, `b_out` equals the A-to-B register through the data path.
- R5: With `ba_use_stored` = 0, `a_out` equals `b_in` through the data path. With `ba_use_stored` = 1, `a_out` equals the B-to-A register through the data path.
- R6: When a select toggles and the live and stored values differ, the output changes once, directly from the old source value to the new one.
- R7: With `INVERT` = 0 the data path passes each bit unchanged. With `INVERT` = 1 it flips every bit, in both directions.
- R8: A capture edge that sees `rst_n` low clears that register to all zeros.
- R9: Set both selects to live and enable both directions. A value placed on either bus appears on the other one. Both buses then keep that value after the outside driver releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous reset, active low, sampled on each capture clock |
| ab_cap_clk | input | 1 | Rising edge captures A into the A-to-B register |
| ba_cap_clk | input | 1 | Rising edge captures B into the B-to-A register |
| drive_b_en | input | 1 | Enables driving of bus B, active high |
| drive_a_en_n | input | 1 | Enables driving of bus A, active low |
| ab_use_stored | input | 1 | Source for B: 0 selects live A, 1 selects the stored value |
| ba_use_stored | input | 1 | Source for A: 0 selects live B, 1 selects the stored value |
| a_in | input | W | Value present on bus A |
| a_out | output | W | Data driven onto bus A |
| a_oe | output | 1 | Bus A drive enable |
| b_in | input | W | Value present on bus B |
| b_out | output | W | Data driven onto bus B |
| b_oe | output | 1 | Bus B drive enable |

## Verification
A wrong value in a capture register stays hidden on the live path. It becomes visible on the opposite bus as soon as that direction's select picks the stored value and its enable is on. The random phase therefore toggles the selects and enables independently of the capture pulses. This also exposes captures that are lost or gated by the wrong control. A broken enable or a broken live path shows at the resolved net within a few nanoseconds of the input change. A hold loop that is not closed shows as a wrong value once the outside driver releases.

// File: rtl/regbus_xcvr.sv
`timescale 1ns/1ps
module regbus_xcvr #(
  parameter int W = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         rst_n,
  input  logic         ab_cap_clk,
  input  logic         ba_cap_clk,
  input  logic         drive_b_en,
  input  logic         drive_a_en_n,
  input  logic         ab_use_stored,
  input  logic         ba_use_stored,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  localparam logic [W-1:0] FLIP = INVERT ? {W{1'b1}} : {W{1'b0}};

  logic [W-1:0] hold_ab, hold_ba;

  always_ff @(posedge ab_cap_clk)
    if (!rst_n) hold_ab <= '0;
    else        hold_ab <= a_in;

  always_ff @(posedge ba_cap_clk)
    if (!rst_n) hold_ba <= '0;
    else        hold_ba <= b_in;

  assign b_out = (ab_use_stored ? hold_ab : a_in) ^ FLIP;
  assign a_out = (ba_use_stored ? hold_ba : b_in) ^ FLIP;
  assign b_oe  = drive_b_en;
  assign a_oe  = ~drive_a_en_n;

  a_r1_ab_capture: assert property (@(posedge ab_cap_clk) disable iff (!rst_n)
    1'b1 |=> hold_ab == $past(a_in));
  a_r2_ba_capture: assert property (@(posedge ba_cap_clk) disable iff (!rst_n)
    1'b1 |=> hold_ba == $past(b_in));
  a_r4_b_stored: assert property (@(posedge ab_cap_clk) disable iff (!rst_n)
    1'b1 |=> (!ab_use_stored || b_out == ($past(a_in) ^ FLIP)));
  a_r5_a_stored: assert property (@(posedge ba_cap_clk) disable iff (!rst_n)
    1'b1 |=> (!ba_use_stored || a_out == ($past(b_in) ^ FLIP)));
endmodule

// File: tb/regbus_xcvr_test.sv
`timescale 1ns/1ps
module regbus_xcvr_test;
  localparam int W = 8;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n = 0, cab = 0, cba = 0;
  logic en_b = 0, en_a_n = 1, s_ab = 0, s_ba = 0;
  logic [W-1:0] a_net = '0, b_net = '0, a_out, b_out;
  logic a_oe, b_oe;
  logic xa_en = 0, xb_en = 0;
  logic [W-1:0] xa = '0, xb = '0;

  logic [W-1:0] i_a = '0, i_b = '0, ia_out, ib_out;
  logic i_sab = 0, i_sba = 0, ia_oe, ib_oe;

  int n_chk = 0, n_bad = 0, bchg = 0;
  logic [W-1:0] m_ab, m_ba;

  regbus_xcvr #(.W(W), .INVERT(1'b0)) uut (
    .rst_n(rst_n), .ab_cap_clk(cab), .ba_cap_clk(cba),
    .drive_b_en(en_b), .drive_a_en_n(en_a_n),
    .ab_use_stored(s_ab), .ba_use_stored(s_ba),
    .a_in(a_net), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_net), .b_out(b_out), .b_oe(b_oe));

  regbus_xcvr #(.W(W), .INVERT(1'b1)) uut_inv (
    .rst_n(rst_n), .ab_cap_clk(cab), .ba_cap_clk(cba),
    .drive_b_en(1'b1), .drive_a_en_n(1'b0),
    .ab_use_stored(i_sab), .ba_use_stored(i_sba),
    .a_in(i_a), .a_out(ia_out), .a_oe(ia_oe),
    .b_in(i_b), .b_out(ib_out), .b_oe(ib_oe));

  always #1 begin
    a_net = xa_en ? xa : (a_oe ? a_out : a_net);
    b_net = xb_en ? xb : (b_oe ? b_out : b_net);
  end

  always @(b_out) bchg++;

  function automatic logic [W-1:0] path(input logic [W-1:0] v, input bit inv);
    return inv ? ~v : v;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic pulse_ab(); cab = 1; #4; cab = 0; #4; endtask
  task automatic pulse_ba(); cba = 1; #4; cba = 0; #4; endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    process::self().srandom(32'd7151);
    xa_en = 1; xb_en = 1; xa = 8'hA5; xb = 8'h3C;
    i_a = 8'h11; i_b = 8'h22;
    #6; pulse_ab(); pulse_ba();
    rst_n = 1;
    s_ab = 1; s_ba = 1; en_b = 1; en_a_n = 0; i_sab = 1; i_sba = 1;
    xb_en = 0; xa_en = 0; #6;
    chk("R8 reset b_out", b_out, 0);
    chk("R8 reset a_out", a_out, 0);
    chk("R7 R8 inverted reset b", ib_out, 8'hFF);
    chk("R7 R8 inverted reset a", ia_out, 8'hFF);

    // R1 capture with enables off and live select
    en_b = 0; en_a_n = 1; s_ab = 0; s_ba = 0;
    xa_en = 1; xb_en = 1; xa = 8'h5E; xb = 8'hC7; #5;
    pulse_ab(); pulse_ba();
    xa = 8'h01; xb = 8'h02;
    s_ab = 1; s_ba = 1; en_b = 1; en_a_n = 0; xb_en = 1; #5;
    chk("R1 capture regardless of controls", b_out, 8'h5E);
    chk("R2 capture regardless of controls", a_out, 8'hC7);
    chk("R3 b_oe high", b_oe, 1);
    chk("R3 a_oe high", a_oe, 1);

    // R6 single change when swapping source
    s_ab = 0; #5;
    chk("R4 live path", b_out, 8'h01);
    bchg = 0; s_ab = 1; #5;
    chk("R6 stored after swap", b_out, 8'h5E);
    chk("R6 single change", bchg, 1);
    bchg = 0; s_ab = 0; #5;
    chk("R6 live after swap", b_out, 8'h01);
    chk("R6 single change back", bchg, 1);

    // R7 inverting variant
    i_sab = 0; i_sba = 0; i_a = 8'h0F; i_b = 8'h96; #3;
    chk("R7 inverted live b", ib_out, 8'hF0);
    chk("R7 inverted live a", ia_out, 8'h69);
    pulse_ab(); pulse_ba();
    i_a = 8'h00; i_b = 8'h00; i_sab = 1; i_sba = 1; #3;
    chk("R7 inverted stored b", ib_out, 8'hF0);
    chk("R7 inverted stored a", ia_out, 8'h69);

    // Random phase: both buses driven from outside
    m_ab = 8'h5E; m_ba = 8'hC7;
    for (int i = 0; i < 400; i++) begin
      logic pa, pb;
      xa = W'($urandom); xb = W'($urandom); #5;
      pa = 1'($urandom); pb = 1'($urandom);
      if (pa) begin pulse_ab(); m_ab = xa; end
      if (pb) begin pulse_ba(); m_ba = xb; end
      xa = W'($urandom); xb = W'($urandom);
      s_ab = 1'($urandom); s_ba = 1'($urandom);
      en_b = 1'($urandom); en_a_n = 1'($urandom); #5;
      chk("R3 b_oe", b_oe, en_b);
      chk("R3 a_oe", a_oe, !en_a_n);
      if (en_b) chk(s_ab ? "R1 R4 stored to B" : "R4 live to B", b_out, path(s_ab ? m_ab : xa, 0));
      if (!en_a_n) chk(s_ba ? "R2 R5 stored to A" : "R5 live to A", a_out, path(s_ba ? m_ba : xb, 0));
    end

    // R9 hold loop
    s_ab = 0; s_ba = 0; en_b = 1; en_a_n = 0;
    xb_en = 0; xa_en = 1; xa = 8'h5A; #6;
    chk("R9 A reaches B", b_net, 8'h5A);
    xa_en = 0; #12;
    chk("R9 A held", a_net, 8'h5A);
    chk("R9 B held", b_net, 8'h5A);
    xb_en = 1; xb = 8'hC3; #6;
    chk("R9 B reaches A", a_net, 8'hC3);
    xb_en = 0; #12;
    chk("R9 A held after B release", a_net, 8'hC3);
    chk("R9 B held after release", b_net, 8'hC3);

    // R8 reset clears a loaded register
    rst_n = 0; pulse_ab(); rst_n = 1;
    s_ab = 1; #5;
    chk("R8 register cleared", b_out, 0);
    finish_run();
  end
endmodule